// File: doc/BRIEF.md
# DS3 Maintenance Signal Inserter

This block sits in a DS3 transmit path and can replace the outgoing stream with one of two maintenance signals: the alarm indication signal (AIS), sent when the local terminal has detected a failure, or the idle condition, sent when the channel works but carries no traffic. In normal mode the serial stream passes through with one cycle of latency. In either maintenance mode the payload is replaced by a fixed repeating pattern, and chosen overhead bits are forced to fixed values. Framing bits and multiframe alignment bits are regenerated locally. Parity bits are taken from the upstream stream, which computes them.

The upstream source presents one bit per cycle when `bit_en` is high. It pulses `frame_start` together with the first bit of each M-frame. The M-frame is 4760 bits long: seven subframes, each made of eight blocks of 85 bits. The first bit of each block is overhead and the other 84 bits are payload. Inside a subframe, the overhead bits of blocks 0 to 7 are: the subframe bit (X in subframes 1–2, P in subframes 3–4, M in subframes 5–7), then F, C, F, C, F, C, F. The mode is sampled once per frame, so a frame never mixes traffic with a maintenance signal.

Top module: `ds3_maint_inserter`

## Requirements
- R1: `dout_vld` equals `bit_en` delayed by one clock. While `rst_n` is low, and on the clock after it, `dout` and `dout_vld` are 0.
- R2: Mode code 2'b00 (normal), and the unused code 2'b11, pass every bit unchanged. `dout` equals the `din` of the previous enabled bit.
- R3: In AIS mode (code 2'b01), payload bits carry 1,0,1,0,... and `din` is ignored. The first payload bit of every frame is 1.
- R4: In idle mode (code 2'b10), payload bits carry 1,1,0,0,... and `din` is ignored. The first payload bit of every frame is 1.
- R5: In AIS and idle modes, the subframe bits of subframes 1 and 2 (X bits) are sent as 1.
- R6: In AIS mode, all 21 C bits (blocks 2, 4 and 6 of every subframe) are sent as 0.
- R7: In idle mode, the three C bits of subframe 3 are sent as 0, and the C bits of every other subframe are passed from `din`.
- R8: In AIS and idle modes, the F bits of blocks 1, 3, 5 and 7 are regenerated as 1, 0, 0, 1.
- R9: In AIS and idle modes, the M bits of subframes 5, 6 and 7 are regenerated as 0, 1, 0.
- R10: The subframe bits of subframes 3 and 4 (P bits) are always passed from `din`.
- R11: `mode` is sampled only on the first bit of a frame. A change at any other point takes effect at the next frame.
- R12: A bit that has both `bit_en` and `frame_start` set is taken as position 0 of a frame, even in the middle of a frame. Without `frame_start`, the position wraps to 0 after bit 4759.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies `din` as one stream bit in this cycle |
| frame_start | input | 1 | Marks the current enabled bit as the first bit of a frame |
| din | input | 1 | Serial transmit stream, including overhead |
| mode | input | 2 | 00 normal, 01 AIS, 10 idle, 11 normal |
| dout | output | 1 | Serial output, one cycle after its input bit |
| dout_vld | output | 1 | Marks `dout` as carrying a new bit |

## Verification
The assertions assume that reset is held low from time zero and that `frame_start` is only meaningful while `bit_en` is high. They also assume the P-bit values on `din` are already correct, so the P-bit property can only compare the output with the input. The stimulus holds reset with `bit_en` low and inserts random idle cycles between bits. It changes `mode` in the middle of frames, including to the unused code. It also pulses `frame_start` in the middle of a frame to realign the counter, and lets other frames wrap without a start strobe. The reference model repeats each of these situations bit by bit.

// File: rtl/ds3_mnt_pkg.sv
// Shared types for the DS3 maintenance signal inserter.
// Assumes a two-bit mode code at the block edge; code 3 is unused and behaves as normal.
package ds3_mnt_pkg;

    typedef enum logic [1:0] {
        MD_NORMAL = 2'b00,
        MD_AIS    = 2'b01,
        MD_IDLE   = 2'b10
    } mode_e;

    typedef enum logic [2:0] {
        OH_PAY = 3'd0,
        OH_X   = 3'd1,
        OH_P   = 3'd2,
        OH_M   = 3'd3,
        OH_F   = 3'd4,
        OH_C   = 3'd5
    } bit_cls_e;

    // Map the raw mode pins onto a legal mode; the unused code falls back to normal.
    function automatic mode_e decode_mode(input logic [1:0] raw);
        case (raw)
            2'b01:   return MD_AIS;
            2'b10:   return MD_IDLE;
            default: return MD_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/ds3_frame_locator.sv
// Tracks the bit position inside a DS3 M-frame using three nested counters
// (bit in block, block in subframe, subframe in frame) and classifies the current bit.
// Assumes frame_start is only meaningful together with bit_en; outputs describe the
// bit presented this cycle (combinational from the registered position).
module ds3_frame_locator
    import ds3_mnt_pkg::*;
#(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 8,
    parameter int SUBFRAMES  = 7
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_en,
    input  logic     frame_start,
    output bit_cls_e cls,
    output logic     f_val,
    output logic     m_val,
    output logic     cp_zone,
    output logic     first
);

    localparam int BW = $clog2(BLOCK_BITS);
    localparam int KW = $clog2(BLOCKS);
    localparam int SW = $clog2(SUBFRAMES);
    localparam logic [BW-1:0] BIT_LAST = BW'(BLOCK_BITS - 1);
    localparam logic [KW-1:0] BLK_LAST = KW'(BLOCKS - 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(SUBFRAMES - 1);

    logic [BW-1:0] bit_q, bit_e;
    logic [KW-1:0] blk_q, blk_e;
    logic [SW-1:0] sub_q, sub_e;

    // Effective position: a start strobe forces position zero for this bit.
    always_comb begin
        bit_e = frame_start ? '0 : bit_q;
        blk_e = frame_start ? '0 : blk_q;
        sub_e = frame_start ? '0 : sub_q;
    end

    // Advance the nested position counters on every enabled bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
            blk_q <= '0;
            sub_q <= '0;
        end else if (bit_en) begin
            if (bit_e == BIT_LAST) begin
                bit_q <= '0;
                if (blk_e == BLK_LAST) begin
                    blk_q <= '0;
                    sub_q <= (sub_e == SUB_LAST) ? '0 : sub_e + 1'b1;
                end else begin
                    blk_q <= blk_e + 1'b1;
                    sub_q <= sub_e;
                end
            end else begin
                bit_q <= bit_e + 1'b1;
                blk_q <= blk_e;
                sub_q <= sub_e;
            end
        end
    end

    // Classify the current bit from its block and subframe.
    always_comb begin
        if (bit_e != '0)
            cls = OH_PAY;
        else if (blk_e[0])
            cls = OH_F;
        else if (blk_e != '0)
            cls = OH_C;
        else if (sub_e < SW'(2))
            cls = OH_X;
        else if (sub_e < SW'(4))
            cls = OH_P;
        else
            cls = OH_M;
    end

    // Per-position fixed values and flags.
    always_comb begin
        f_val   = (blk_e == KW'(1)) || (blk_e == BLK_LAST);
        m_val   = (sub_e == SW'(5));
        cp_zone = (sub_e == SW'(2));
        first   = (bit_e == '0) && (blk_e == '0) && (sub_e == '0);
    end

endmodule

// File: rtl/ds3_fill_pattern.sv
// Generates the two maintenance payload patterns from a shared phase counter.
// The phase restarts on the first bit of each frame and advances on payload bits only,
// so the first payload bit of every frame is 1 in both patterns.
module ds3_fill_pattern #(
    parameter int PHASE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic first,
    input  logic is_pay,
    output logic ais_bit,
    output logic idle_bit
);

    logic [PHASE_W-1:0] phase_q;

    // Restart at frame start, step once per payload bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (bit_en) begin
            if (first)
                phase_q <= '0;
            else if (is_pay)
                phase_q <= phase_q + 1'b1;
        end
    end

    // AIS alternates every bit, idle every second bit; both start at 1.
    always_comb begin
        ais_bit  = ~phase_q[0];
        idle_bit = ~phase_q[1];
    end

endmodule

// File: rtl/ds3_mnt_mux.sv
// Chooses the outgoing bit from the mode in effect and the class of the current bit.
// Purely combinational; assumes the classification and pattern bits refer to the same bit.
module ds3_mnt_mux
    import ds3_mnt_pkg::*;
(
    input  mode_e    md,
    input  bit_cls_e cls,
    input  logic     din,
    input  logic     f_val,
    input  logic     m_val,
    input  logic     cp_zone,
    input  logic     ais_bit,
    input  logic     idle_bit,
    output logic     bit_out
);

    // Substitute forced values per class; P bits and normal traffic pass through.
    always_comb begin
        bit_out = din;
        if (md != MD_NORMAL) begin
            case (cls)
                OH_PAY:  bit_out = (md == MD_AIS) ? ais_bit : idle_bit;
                OH_X:    bit_out = 1'b1;
                OH_F:    bit_out = f_val;
                OH_M:    bit_out = m_val;
                OH_C:    bit_out = (md == MD_AIS || cp_zone) ? 1'b0 : din;
                default: bit_out = din;
            endcase
        end
    end

endmodule

// File: rtl/ds3_maint_inserter.sv
// Top of the DS3 maintenance signal inserter. Latches the mode at each frame start,
// selects the outgoing bit and registers it with its valid flag.
// Assumes the upstream stream carries correct P bits and pulses frame_start with bit_en.
module ds3_maint_inserter
    import ds3_mnt_pkg::*;
#(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 8,
    parameter int SUBFRAMES  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       frame_start,
    input  logic       din,
    input  logic [1:0] mode,
    output logic       dout,
    output logic       dout_vld
);

    bit_cls_e loc_cls;
    logic     loc_f, loc_m, loc_cp, loc_first;
    logic     pat_ais, pat_idle, mux_bit;
    mode_e    held_mode, cur_mode;

    ds3_frame_locator #(
        .BLOCK_BITS(BLOCK_BITS),
        .BLOCKS    (BLOCKS),
        .SUBFRAMES (SUBFRAMES)
    ) u_loc (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .frame_start(frame_start),
        .cls        (loc_cls),
        .f_val      (loc_f),
        .m_val      (loc_m),
        .cp_zone    (loc_cp),
        .first      (loc_first)
    );

    ds3_fill_pattern #(.PHASE_W(2)) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .first   (loc_first),
        .is_pay  (loc_cls == OH_PAY),
        .ais_bit (pat_ais),
        .idle_bit(pat_idle)
    );

    // Mode for this bit: freshly sampled on the first bit, otherwise the held one.
    always_comb cur_mode = loc_first ? decode_mode(mode) : held_mode;

    // Hold the mode for the rest of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_mode <= MD_NORMAL;
        else if (bit_en && loc_first)
            held_mode <= cur_mode;
    end

    ds3_mnt_mux u_mux (
        .md      (cur_mode),
        .cls     (loc_cls),
        .din     (din),
        .f_val   (loc_f),
        .m_val   (loc_m),
        .cp_zone (loc_cp),
        .ais_bit (pat_ais),
        .idle_bit(pat_idle),
        .bit_out (mux_bit)
    );

    // Register the output bit and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= 1'b0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= bit_en;
            if (bit_en)
                dout <= mux_bit;
        end
    end

endmodule

// File: rtl/ds3_maint_chk.sv
// Property checker for the DS3 maintenance signal inserter, attached by bind.
// Assumes reset is low from time zero.
module ds3_maint_chk
    import ds3_mnt_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     bit_en,
    input logic     din,
    input logic     dout,
    input logic     dout_vld,
    input mode_e    cur_mode,
    input mode_e    held_mode,
    input bit_cls_e cls,
    input logic     first
);

    // R1
    vld_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dout_vld == $past(bit_en)));

    // R2
    normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cur_mode == MD_NORMAL) |=> (dout == $past(din)));

    // R5
    x_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cur_mode != MD_NORMAL && cls == OH_X) |=> dout);

    // R6
    ais_c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cur_mode == MD_AIS && cls == OH_C) |=> !dout);

    // R10
    p_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cls == OH_P) |=> (dout == $past(din)));

    // R11
    mode_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_mode != $past(held_mode)) |-> $past(bit_en && first));

    // R1
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en) |=> $stable(dout));

endmodule

bind ds3_maint_inserter ds3_maint_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .din      (din),
    .dout     (dout),
    .dout_vld (dout_vld),
    .cur_mode (cur_mode),
    .held_mode(held_mode),
    .cls      (loc_cls),
    .first    (loc_first)
);

// File: tb/tb_ds3_maint_inserter.sv
module tb_ds3_maint_inserter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       frame_start = 1'b0;
    logic       din = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       dout, dout_vld;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Reference model state
    int ref_pos = 0;
    int ref_mode = 0;
    int ref_pc = 0;
    logic  exp_d = 1'b0;
    logic  exp_v = 1'b0;
    string tag = "R2";
    int    last_p = 0;

    always #4 clk = ~clk;

    ds3_maint_inserter dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
        .din(din), .mode(mode), .dout(dout), .dout_vld(dout_vld)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=200000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input logic act, input logic expv, input string t);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s pos=%0d actual=%b expected=%b", t, last_p, act, expv);
        end
    endtask

    // Behavioural model of one enabled bit; fills exp_d and tag.
    task automatic model(input logic fs, input logic d, input logic [1:0] m);
        int p, off, blk, sub, k, mn;
        mn = (m == 2'b11) ? 0 : int'(m);
        p = fs ? 0 : ref_pos;
        tag = "R2";
        if (fs && ref_pos != 0) tag = "R12";
        if (p == 0) begin
            ref_mode = mn;
            ref_pc = 0;
        end else if (mn != ref_mode) begin
            tag = "R11";
        end
        off = p % 85;
        blk = (p % 680) / 85;
        sub = p / 680;
        if (ref_mode == 0) begin
            exp_d = d;
        end else if (off != 0) begin
            k = ref_pc % 4;
            ref_pc++;
            if (ref_mode == 1) begin exp_d = (k % 2 == 0); if (tag == "R2") tag = "R3"; end
            else               begin exp_d = (k < 2);      if (tag == "R2") tag = "R4"; end
        end else if (blk == 0) begin
            if (sub < 2)      begin exp_d = 1'b1; tag = "R5"; end
            else if (sub < 4) begin exp_d = d;    tag = "R10"; end
            else              begin exp_d = (sub == 5); tag = "R9"; end
        end else if (blk % 2 == 1) begin
            exp_d = (blk == 1 || blk == 7); tag = "R8";
        end else begin
            if (ref_mode == 1) begin exp_d = 1'b0; tag = "R6"; end
            else begin exp_d = (sub == 2) ? 1'b0 : d; tag = "R7"; end
        end
        if (ref_mode != 0 && off != 0 && p < 86) tag = (ref_mode == 1) ? "R3" : "R4";
        last_p = p;
        ref_pos = (p + 1) % 4760;
    endtask

    // Drive one cycle at the falling edge and check the result one edge later.
    task automatic step(input logic en, input logic fs, input logic d, input logic [1:0] m);
        bit_en = en; frame_start = fs; din = d; mode = m;
        exp_v = en;
        if (en) model(fs, d, m);
        @(negedge clk);
        check(dout_vld, exp_v, "R1");
        if (exp_v) check(dout, exp_d, tag);
    endtask

    task automatic run_bits(input int n, input logic [1:0] m, input logic fs_first);
        for (int i = 0; i < n; i++) begin
            if ($urandom % 8 == 0) step(1'b0, 1'b0, 1'($urandom), m);
            step(1'b1, (i == 0) && fs_first, 1'($urandom), m);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dout, 1'b0, "R1");
        check(dout_vld, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(dout_vld, 1'b0, "R1");
        // R2 normal frame, mode raised to AIS mid-frame (R11)
        run_bits(2000, 2'b00, 1'b1);
        run_bits(2760, 2'b01, 1'b0);
        // R3/R6 AIS frame entered by wrap (R12), idle requested mid-frame (R11)
        run_bits(3000, 2'b01, 1'b0);
        run_bits(1760, 2'b10, 1'b0);
        // R4/R7 idle frame, realigned mid-frame by a start strobe into AIS (R12)
        run_bits(3000, 2'b10, 1'b0);
        run_bits(4760, 2'b01, 1'b1);
        // Unused code behaves as normal (R2)
        run_bits(4760, 2'b11, 1'b0);
        run_bits(4760, 2'b10, 1'b0);
        step(1'b0, 1'b0, 1'b0, 2'b00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule